// File: doc/BRIEF.md
# Global History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a single shift register that holds the outcomes of the most recently resolved branches. The value of that register is used, unchanged, as the index into a table of two-bit saturating counters. No branch address takes part in the index. One branch's behaviour can therefore steer the guess made for the branch after it.

A front end raises `pred_req` and receives `pred_vld` with `pred_taken` on the following cycle. A back end reports each resolved branch on `upd_vld`/`upd_taken`. On that clock edge the block trains the counter selected by the history as it stood before the update, and then shifts the outcome into the history. The current history is visible on `hist_o`, so a caller can record it next to each prediction.

Every table entry is a small state machine with four states, ordered as follows:
- `CTR_SN`: strongly not taken, encoding 2'b00.
- `CTR_WN`: weakly not taken, encoding 2'b01.
- `CTR_WT`: weakly taken, encoding 2'b10.
- `CTR_ST`: strongly taken, encoding 2'b11.

Each entry has four transitions:
- Step up: a taken outcome moves the entry one state toward `CTR_ST`.
- Step down: a not-taken outcome moves the entry one state toward `CTR_SN`.
- Saturate: an entry already at the end state in the direction of the outcome stays where it is.
- Hold: an entry that is not selected for training keeps its state.

Top module: `bhp_global`

## Requirements
- R1: While `rst_n` is low and after its release, `hist_o` is all zeros and `pred_vld` is low until a prediction is requested.
- R2: Every counter resets to `CTR_WN`. A prediction made before an entry has been trained is therefore not taken (`pred_taken` = 0).
- R3: `pred_vld` is high in exactly the cycle after a cycle in which `pred_req` is high. `pred_taken` is 1 when the counter indexed by `hist_o` in the request cycle is in `CTR_WT` or `CTR_ST`.
- R4: On an update, `hist_o` becomes `{hist_o[HIST_W-2:0], upd_taken}`: taken = 1 enters at bit 0 and the oldest bit (the MSB) is dropped. Without an update, `hist_o` holds its value.
- R5: A taken outcome moves the selected counter one state up and saturates at `CTR_ST`.
- R6: A not-taken outcome moves the selected counter one state down and saturates at `CTR_SN`.
- R7: One not-taken outcome applied to a counter in `CTR_ST` leaves it in `CTR_WT`, so the next prediction from that entry is still taken.
- R8: An update trains only the entry indexed by `hist_o` before the shift. All other entries keep their state.
- R9: When `pred_req` and `upd_vld` are high in the same cycle, the prediction uses the history and counter values from before that update.
- R10: The table holds 2^HIST_W entries, and each reachable history value selects its own entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_req | input | 1 | Request a direction guess for the current history |
| pred_vld | output | 1 | Guess is valid, one cycle after `pred_req` |
| pred_taken | output | 1 | Guess: 1 = taken |
| upd_vld | input | 1 | A resolved branch outcome is present |
| upd_taken | input | 1 | Resolved outcome: 1 = taken |
| hist_o | output | HIST_W | Current global outcome history |

## Verification
The hardest case to reach from the ports is training one chosen table entry several times in a row. Each update also moves the history, and therefore moves the index away from that entry. The stimulus uses the fixed points of the shift: runs of not-taken outcomes hold the index at all zeros, and runs of taken outcomes hold it at all ones. This lets counters be driven into both saturated states. To go back to the all-ones entry after a not-taken outcome, the stimulus feeds exactly HIST_W taken outcomes, which brings the index back round and checks the hysteresis case. A long stretch of random outcomes then visits the other entries, with predictions and updates that overlap in the same cycle.

// File: rtl/bhp_pkg.sv
package bhp_pkg;

    // Two-bit direction counter; bit 1 set means the entry leans taken.
    typedef enum logic [1:0] {
        CTR_SN = 2'b00,
        CTR_WN = 2'b01,
        CTR_WT = 2'b10,
        CTR_ST = 2'b11
    } ctr_t;

    localparam ctr_t CTR_RESET = CTR_WN;

endpackage

// File: rtl/bhp_hist.sv
module bhp_hist #(
    parameter int HIST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              shift_bit,
    output logic [HIST_W-1:0] hist
);

    logic [HIST_W-1:0] hist_q;
    logic [HIST_W-1:0] hist_d;

    always_comb begin
        hist_d = hist_q;
        if (shift_en) begin
            hist_d = {hist_q[HIST_W-2:0], shift_bit};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    assign hist = hist_q;

endmodule

// File: rtl/bhp_ctr.sv
module bhp_ctr
    import bhp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic train_en,
    input  logic outcome,
    output ctr_t state,
    output logic lean_taken
);

    ctr_t state_q;
    ctr_t state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CTR_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: step up, step down, saturate, hold
    always_comb begin
        state_d = state_q;
        if (train_en) begin
            unique case (state_q)
                CTR_SN: state_d = outcome ? CTR_WN : CTR_SN;
                CTR_WN: state_d = outcome ? CTR_WT : CTR_SN;
                CTR_WT: state_d = outcome ? CTR_ST : CTR_WN;
                CTR_ST: state_d = outcome ? CTR_ST : CTR_WT;
            endcase
        end
    end

    // Outputs
    always_comb begin
        state = state_q;
        unique case (state_q)
            CTR_SN, CTR_WN: lean_taken = 1'b0;
            CTR_WT, CTR_ST: lean_taken = 1'b1;
        endcase
    end

endmodule

// File: rtl/bhp_global.sv
module bhp_global
    import bhp_pkg::*;
#(
    parameter int HIST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pred_req,
    output logic              pred_vld,
    output logic              pred_taken,
    input  logic              upd_vld,
    input  logic              upd_taken,
    output logic [HIST_W-1:0] hist_o
);

    localparam int ENTRIES = 1 << HIST_W;

    logic [HIST_W-1:0]    hist;
    logic [ENTRIES-1:0]   lean;
    logic [2*ENTRIES-1:0] ent_flat;
    logic                 pred_vld_q;
    logic                 pred_taken_q;

    bhp_hist #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (upd_vld),
        .shift_bit(upd_taken),
        .hist     (hist)
    );

    // One counter state machine per history value
    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        ctr_t st;
        logic sel;
        assign sel = upd_vld && (hist == HIST_W'(i));
        bhp_ctr u_ctr (
            .clk       (clk),
            .rst_n     (rst_n),
            .train_en  (sel),
            .outcome   (upd_taken),
            .state     (st),
            .lean_taken(lean[i])
        );
        assign ent_flat[2*i +: 2] = st;
    end

    // Registered prediction, read from pre-update history and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pred_vld_q   <= 1'b0;
            pred_taken_q <= 1'b0;
        end else begin
            pred_vld_q <= pred_req;
            if (pred_req) begin
                pred_taken_q <= lean[hist];
            end
        end
    end

    assign pred_vld   = pred_vld_q;
    assign pred_taken = pred_taken_q;
    assign hist_o     = hist;

endmodule

// File: rtl/bhp_global_chk.sv
module bhp_global_chk
    import bhp_pkg::*;
#(
    parameter int HIST_W = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       pred_req,
    input logic                       pred_vld,
    input logic                       upd_vld,
    input logic                       upd_taken,
    input logic [HIST_W-1:0]          hist_o,
    input logic [2*(1<<HIST_W)-1:0]   ent_flat
);

    // R4
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_vld |=> hist_o == {$past(hist_o[HIST_W-2:0]), $past(upd_taken)});

    // R4
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_vld |=> $stable(hist_o));

    // R3
    pred_vld_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_req |=> pred_vld);

    // R3
    pred_vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_req |=> !pred_vld);

    // R5
    sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_vld && upd_taken && ent_flat[2*hist_o +: 2] == CTR_ST)
        |=> ent_flat[2*$past(hist_o) +: 2] == CTR_ST);

    // R6
    sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_vld && !upd_taken && ent_flat[2*hist_o +: 2] == CTR_SN)
        |=> ent_flat[2*$past(hist_o) +: 2] == CTR_SN);

    // R7
    hysteresis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_vld && !upd_taken && ent_flat[2*hist_o +: 2] == CTR_ST)
        |=> ent_flat[2*$past(hist_o) +: 2] == CTR_WT);

    // R8
    no_update_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_vld |=> $stable(ent_flat));

endmodule

bind bhp_global bhp_global_chk #(.HIST_W(HIST_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pred_req (pred_req),
    .pred_vld (pred_vld),
    .upd_vld  (upd_vld),
    .upd_taken(upd_taken),
    .hist_o   (hist_o),
    .ent_flat (ent_flat)
);

// File: tb/bhp_global_bench.sv
`timescale 1ns/1ps
module bhp_global_bench;

    localparam int HW  = 4;
    localparam int NE  = 1 << HW;
    localparam int MAX_CYC = 200000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pred_req = 1'b0;
    logic          upd_vld = 1'b0;
    logic          upd_taken = 1'b0;
    logic          pred_vld;
    logic          pred_taken;
    logic [HW-1:0] hist_o;

    int checks = 0;
    int bad = 0;
    bit finished = 0;

    // Reference model built from the requirements
    logic [1:0]    mdl [NE];
    logic [HW-1:0] mhist;

    bit    exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    bhp_global #(.HIST_W(HW)) u_bhp_global (
        .clk       (clk),
        .rst_n     (rst_n),
        .pred_req  (pred_req),
        .pred_vld  (pred_vld),
        .pred_taken(pred_taken),
        .upd_vld   (upd_vld),
        .upd_taken (upd_taken),
        .hist_o    (hist_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus, pushes expected prediction
    task automatic step(input bit pr, input bit up, input bit ut, input string tag);
        @(negedge clk);
        chk(hist_o == mhist, "R4", int'(hist_o), int'(mhist));
        pred_req  = pr;
        upd_vld   = up;
        upd_taken = ut;
        if (pr) begin
            exp_q.push_back(mdl[mhist][1]);   // R9: pre-update value
            tag_q.push_back(tag);
        end
        if (up) begin
            if (ut && mdl[mhist] != 2'b11) mdl[mhist] = mdl[mhist] + 2'd1;
            if (!ut && mdl[mhist] != 2'b00) mdl[mhist] = mdl[mhist] - 2'd1;
            mhist = {mhist[HW-2:0], ut};
        end
    endtask

    // Monitor: pops expected guesses as the design produces them
    always @(negedge clk) begin
        if (rst_n && pred_vld) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3", 1, 0);
            end else begin
                automatic bit    e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(pred_taken == e, t, int'(pred_taken), int'(e));
            end
        end
    end

    initial begin
        #(MAX_CYC * 8);
        if (!finished) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NE; i++) mdl[i] = 2'b01;
        mhist = '0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(hist_o == '0, "R1", int'(hist_o), 0);
        chk(pred_vld == 1'b0, "R1", int'(pred_vld), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pred_vld == 1'b0, "R1", int'(pred_vld), 0);

        step(1, 0, 0, "R2");          // untrained entry 0 -> not taken
        step(0, 1, 0, "R6");          // WN -> SN
        step(0, 1, 0, "R6");          // saturates at SN
        step(1, 1, 1, "R9");          // guess from SN, then SN -> WN
        step(1, 0, 0, "R8");          // entry 0001 untouched -> not taken
        step(0, 1, 1, "R4");
        step(0, 1, 1, "R4");
        step(0, 1, 1, "R4");          // history now all ones
        step(0, 1, 1, "R5");
        step(0, 1, 1, "R5");
        step(0, 1, 1, "R5");          // saturates at ST
        step(1, 0, 0, "R5");          // taken
        step(1, 1, 0, "R9");          // guess taken, ST -> WT
        for (int k = 0; k < HW; k++) step(0, 1, 1, "R4");
        step(1, 0, 0, "R7");          // back at all ones, still taken
        step(1, 0, 0, "R10");

        // Random mix visiting all entries, overlap of predict and update
        for (int n = 0; n < 600; n++) begin
            automatic bit pr = $urandom_range(0, 1) == 1;
            automatic bit up = $urandom_range(0, 2) != 0;
            automatic bit ut = $urandom_range(0, 3) != 0;
            step(pr, up, ut, "R10");
        end
        step(0, 0, 0, "R3");
        step(0, 0, 0, "R3");
        @(negedge clk);
        chk(exp_q.size() == 0, "R3", exp_q.size(), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule